// File: doc/BRIEF.md
# Nibble Parity Calibration Decoder

This block turns eight protected storage bytes into a pair of 16-bit calibration points. Each stored byte carries one data nibble in its low half and four check bits in its high half. Each check bit is the exclusive-or of a fixed pair of the data bits. The decoder recomputes the check half of every byte from its nibble and compares the whole byte. It joins the nibbles of adjacent bytes into data bytes and packs four data bytes into a 32-bit calibration word. The low half of that word is the lower calibration point and the high half is the upper point.

A host presents all eight bytes at once and raises a one-cycle strobe. One clock later the decoder presents its result with a one-cycle valid pulse. A flag reports whether any byte failed its check. The decoder corrects nothing: a single wrong byte marks the whole result as bad and forces both points to zero. Between strobes, the results stay as they are.

Top module: `calib_nibble_decoder`

## Requirements
- R1: After reset, outValid, outError, calLow and calHigh are all zero.
- R2: A stored byte is accepted only when all eight bits equal the byte built from its low nibble d[3:0], where bit 4 = d0^d1, bit 5 = d2^d3, bit 6 = d0^d2 and bit 7 = d1^d3.
- R3: A mismatch in any one of the eight input bytes, in a check bit or in a data bit, sets outError for that result.
- R4: Input byte i sits at codeBytes[8i+7:8i]. For pair k, byte 2k gives the low nibble of data byte k and byte 2k+1 gives its high nibble.
- R5: Data byte k fills bits [8k+7:8k] of the 32-bit word. calLow is bits [15:0] and calHigh is bits [31:16].
- R6: outValid is high in exactly the cycle after each cycle in which inValid is sampled high, and low otherwise.
- R7: While outError is high, calLow and calHigh are zero.
- R8: While inValid is low, a change on codeBytes has no effect, and outError, calLow and calHigh keep their values.
- R9: A clean decode after a failed one clears outError and presents the new points.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: codeBytes is sampled at this edge |
| codeBytes | input | 64 | Eight stored bytes, byte i at [8i+7:8i] |
| outValid | output | 1 | One-cycle pulse: a new result is presented |
| outError | output | 1 | At least one byte of the last sample failed its check |
| calLow | output | 16 | Lower calibration point |
| calHigh | output | 16 | Upper calibration point |

## Verification
The assertions assume that inValid is a clean synchronous signal. They also assume that codeBytes matters only in a cycle where the strobe is high. Nothing in them constrains the byte contents, so any pattern is legal. The bench drives every input on the falling clock edge. It lowers the strobe one cycle after each sample. It also changes codeBytes while the strobe is low, so that the hold property meets real input activity.

// File: rtl/calib_pkg.sv
package calib_pkg;

  localparam int NIBBLE_W = 4;
  localparam int CODE_W   = 2 * NIBBLE_W;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  // Build the protected byte for one data nibble.
  function automatic logic [CODE_W-1:0] encodeNibble(input logic [NIBBLE_W-1:0] n);
    return {n[1] ^ n[3], n[0] ^ n[2], n[2] ^ n[3], n[0] ^ n[1], n};
  endfunction

endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe      = '0;
    strobe.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/calib_datapath.sv
module calib_datapath
  import calib_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strobe,
  input  logic [2*DATA_BYTES*CODE_W-1:0] codeBytes,
  output logic                           errFlag,
  output logic [DATA_BYTES*CODE_W-1:0]   dataWord
);

  localparam int CODE_BYTES = 2 * DATA_BYTES;
  localparam int WORD_W     = DATA_BYTES * CODE_W;

  logic [CODE_BYTES-1:0] byteOk;
  logic [WORD_W-1:0]     rawWord;
  logic                  anyBad;

  for (genvar i = 0; i < CODE_BYTES; i++) begin : g_check
    logic [CODE_W-1:0] cb;
    assign cb        = codeBytes[i*CODE_W +: CODE_W];
    assign byteOk[i] = (cb == encodeNibble(cb[NIBBLE_W-1:0]));
  end

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_pair
    // even byte carries the low nibble, odd byte the high nibble
    assign rawWord[k*CODE_W +: NIBBLE_W] =
      codeBytes[(2*k)*CODE_W +: NIBBLE_W];
    assign rawWord[k*CODE_W + NIBBLE_W +: NIBBLE_W] =
      codeBytes[(2*k+1)*CODE_W +: NIBBLE_W];
  end

  assign anyBad = ~&byteOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      dataWord <= '0;
    end else if (strobe.load) begin
      errFlag  <= anyBad;
      dataWord <= anyBad ? '0 : rawWord;
    end
  end

endmodule

// File: rtl/calib_nibble_decoder.sv
module calib_nibble_decoder
  import calib_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 inValid,
  input  logic [2*DATA_BYTES*CODE_W-1:0]       codeBytes,
  output logic                                 outValid,
  output logic                                 outError,
  output logic [DATA_BYTES*CODE_W/2-1:0]       calLow,
  output logic [DATA_BYTES*CODE_W/2-1:0]       calHigh
);

  localparam int WORD_W  = DATA_BYTES * CODE_W;
  localparam int POINT_W = WORD_W / 2;

  ctrlStrobe_t       strobe;
  logic [WORD_W-1:0] dataWord;

  calib_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  calib_datapath #(.DATA_BYTES(DATA_BYTES)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .codeBytes (codeBytes),
    .errFlag   (outError),
    .dataWord  (dataWord)
  );

  assign calLow  = dataWord[POINT_W-1:0];
  assign calHigh = dataWord[WORD_W-1:POINT_W];

endmodule

// File: rtl/calib_decoder_chk.sv
module calib_decoder_chk #(
  parameter int POINT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               outValid,
  input logic               outError,
  input logic [POINT_W-1:0] calLow,
  input logic [POINT_W-1:0] calHigh
);

  // R6
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7
  error_zeroes_points_chk: assert property (@(posedge clk) disable iff (!rstN)
    outError |-> (calLow == '0 && calHigh == '0));

  // R8
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(calLow) && $stable(calHigh) && $stable(outError)));

endmodule

bind calib_nibble_decoder calib_decoder_chk #(.POINT_W(POINT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outError (outError),
  .calLow   (calLow),
  .calHigh  (calHigh)
);

// File: tb/test_calib_nibble_decoder.sv
module test_calib_nibble_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] codeBytes = '0;
  logic        outValid, outError;
  logic [15:0] calLow, calHigh;
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  calib_nibble_decoder i_calib_nibble_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .codeBytes(codeBytes),
    .outValid(outValid), .outError(outError), .calLow(calLow), .calHigh(calHigh)
  );

  // {data word, corrupted byte index (8 = none), xor mask}
  localparam logic [47:0] VECS [8] = '{
    {32'h0000_0000, 8'd8, 8'h00},
    {32'hFFFF_FFFF, 8'd8, 8'h00},
    {32'h1234_5678, 8'd8, 8'h00},
    {32'hA5C3_0F96, 8'd8, 8'h00},
    {32'h1234_5678, 8'd0, 8'h80},
    {32'h1234_5678, 8'd7, 8'h10},
    {32'hDEAD_BEEF, 8'd3, 8'h01},
    {32'h8001_7FFE, 8'd8, 8'h00}
  };

  function automatic logic [7:0] protect(input logic [3:0] d);
    logic [7:0] b;
    b[3:0] = d;
    b[4] = d[0] ^ d[1];
    b[5] = d[2] ^ d[3];
    b[6] = d[0] ^ d[2];
    b[7] = d[1] ^ d[3];
    return b;
  endfunction

  function automatic logic [63:0] buildBytes(input logic [31:0] w);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      r[16*k +: 8]     = protect(w[8*k +: 4]);
      r[16*k + 8 +: 8] = protect(w[8*k + 4 +: 4]);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one sample, then check the result one edge later.
  task automatic runVec(input logic [31:0] w, input int idx, input logic [7:0] mask,
                        input string tag);
    logic [63:0] b;
    logic        bad;
    b = buildBytes(w);
    bad = (idx < 8) && (mask != 8'h00);
    if (idx < 8) b[8*idx +: 8] = b[8*idx +: 8] ^ mask;
    @(negedge clk);
    codeBytes = b;
    inValid   = 1'b1;
    @(negedge clk);
    inValid   = 1'b0;
    chk({tag, " R6 outValid"}, {31'd0, outValid}, 32'd1);
    chk({tag, " R2/R3 outError"}, {31'd0, outError}, {31'd0, bad});
    chk({tag, " R5/R7 calLow"}, {16'd0, calLow}, bad ? 32'd0 : {16'd0, w[15:0]});
    chk({tag, " R4/R5 calHigh"}, {16'd0, calHigh}, bad ? 32'd0 : {16'd0, w[31:16]});
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] keepLo, keepHi;
    logic        keepErr;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", {31'd0, outValid}, 32'd0);
    chk("R1 outError", {31'd0, outError}, 32'd0);
    chk("R1 calLow", {16'd0, calLow}, 32'd0);
    chk("R1 calHigh", {16'd0, calHigh}, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < 8; v++) begin
      runVec(VECS[v][47:16], int'(VECS[v][15:8]), VECS[v][7:0], $sformatf("vec%0d", v));
      @(negedge clk);
      chk("R6 pulse ends", {31'd0, outValid}, 32'd0);
    end

    // R3: every byte position, check and data halves
    for (int i = 0; i < 8; i++) begin
      runVec(32'h3C5A_96E1, i, 8'h40, "R3 check-bit flip");
      runVec(32'h3C5A_96E1, i, 8'h04, "R3 data-bit flip");
    end

    // R9: a clean sample after an error clears the flag
    runVec(32'h0102_0304, 2, 8'h20, "R9 setup");
    runVec(32'hCAFE_0BAD, 8, 8'h00, "R9 recover");

    // R8: changes on the byte inputs without a strobe are ignored
    keepLo = calLow; keepHi = calHigh; keepErr = outError;
    @(negedge clk);
    codeBytes = buildBytes(32'h1111_2222);
    @(negedge clk);
    codeBytes = 64'hFFFF_0000_1234_ABCD;
    @(negedge clk);
    chk("R8 outValid", {31'd0, outValid}, 32'd0);
    chk("R8 calLow", {16'd0, calLow}, {16'd0, keepLo});
    chk("R8 calHigh", {16'd0, calHigh}, {16'd0, keepHi});
    chk("R8 outError", {31'd0, outError}, {31'd0, keepErr});

    // R6: back-to-back strobes give back-to-back results
    @(negedge clk);
    codeBytes = buildBytes(32'h0000_00FF);
    inValid = 1'b1;
    @(negedge clk);
    codeBytes = buildBytes(32'h00FF_0000);
    chk("R6 first of two", {31'd0, outValid}, 32'd1);
    chk("R5 first calLow", {16'd0, calLow}, 32'h0000_00FF);
    @(negedge clk);
    inValid = 1'b0;
    chk("R6 second of two", {31'd0, outValid}, 32'd1);
    chk("R5 second calHigh", {16'd0, calHigh}, 32'h0000_00FF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule